// File: doc/BRIEF.md
# Region-Tagged Translation Buffer with Key Check

This block is a fully associative address translation buffer for a 64-bit virtual address space. The top three address bits pick one of eight region registers, and the identifier held there tags every lookup. An entry answers a lookup only when both its region identifier and its masked virtual page number agree with the request. Rewriting a region register changes which entries can answer, so no flush is needed on a context switch, and two contexts that load the same identifier share entries.

A hitting entry returns a physical page number, a three-bit rights field, a privilege ceiling and a protection key. The key is searched for in a small file of key registers, and the access is allowed only when a matching key register exists and both the entry and that register permit the requested access type. Entries are written either into pinned slots chosen by software or into cache slots chosen by a round-robin pointer. A ranged purge clears cache entries of one region identifier that overlap a naturally aligned window of 4 KB to 4 GB. The result of a lookup appears one clock after the request.

Top module: `region_tlb`

## Requirements
- R1: Address bits 63:61 of a lookup select the region register whose identifier is compared. After a region register is rewritten, entries inserted under the old identifier miss; writing the old value back makes them hit again.
- R2: A lookup hits only if a valid entry has an equal region identifier and an equal virtual page number above the entry's page size. With no such entry the result flags a miss (res_miss=1, other flags 0, res_pa=0).
- R3: The page size code gives 4K, 8K, 16K, 64K, 256K, 1M, 4M, 16M, 64M, 256M for codes 0 to 9. On an allowed hit res_pa holds the stored page number (4 KB units) above the page size and the request address below it.
- R4: If the hitting entry's key matches no valid key register, the result flags a key fault (res_key_fault=1).
- R5: The access type is 0 read, 1 write, 2 execute, 3 never allowed; rights bit 2 permits read, bit 1 write, bit 0 execute. The access is allowed only if the entry bit and the matching key register bit are both set and the request privilege is not above the entry's (numerically less or equal); otherwise res_acc_fault=1. Miss takes priority over key fault, key fault over access fault.
- R6: An insert with ins_pinned=1 writes the pinned slot ins_slot; pinned entries are never replaced by cache inserts and are never cleared by purges.
- R7: Inserts with ins_pinned=0 fill the cache slots in round-robin order, so the fifth cache insert (with four cache slots) replaces the first.
- R8: A purge with base page pg_page and window 2^pg_log2 bytes (clamped to 12..32) clears every cache entry whose region identifier equals pg_rid and whose page overlaps the window; entries of other identifiers or outside the window stay.
- R9: res_valid rises exactly one clock after req_valid. Region, key, insert and purge writes in the same cycle as a lookup are not seen by that lookup but are seen by the next.
- R10: After reset all entries and key registers are invalid, region registers hold zero and res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 64 | Lookup virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_pl | input | 2 | Request privilege level, 0 most privileged |
| res_valid | output | 1 | Lookup result valid |
| res_ok | output | 1 | Access allowed |
| res_miss | output | 1 | No entry matched |
| res_key_fault | output | 1 | Entry key not found in key registers |
| res_acc_fault | output | 1 | Rights or privilege deny the access |
| res_pa | output | PA_W | Physical address on an allowed hit |
| rr_we | input | 1 | Region register write |
| rr_idx | input | 3 | Region register index |
| rr_rid | input | RID_W | Region identifier to write |
| pk_we | input | 1 | Key register write |
| pk_idx | input | clog2(NUM_KEYS) | Key register index |
| pk_valid | input | 1 | Key register valid bit |
| pk_key | input | KEY_W | Key value |
| pk_rwx | input | 3 | Key register permissions (read, write, execute) |
| ins_valid | input | 1 | Insert request |
| ins_pinned | input | 1 | 1: pinned slot, 0: round-robin cache slot |
| ins_slot | input | clog2(NUM_TR) | Pinned slot index |
| ins_region | input | 3 | Address bits 63:61 of the page being inserted |
| ins_vpn | input | 49 | Address bits 60:12 of the page |
| ins_ps | input | 4 | Page size code |
| ins_ppn | input | PA_W-12 | Physical page number in 4 KB units |
| ins_rwx | input | 3 | Entry rights |
| ins_pl | input | 2 | Entry privilege ceiling |
| ins_key | input | KEY_W | Entry protection key |
| pg_valid | input | 1 | Purge request |
| pg_rid | input | RID_W | Region identifier to purge |
| pg_page | input | 49 | Purge base address bits 60:12 |
| pg_log2 | input | 6 | Purge window size as log2 bytes |

## Verification
The assertions take for granted that software never leaves two valid entries with the same region identifier whose pages overlap, so at most one entry matches any lookup; the stimulus places every page at a distinct address or identifier and checks that property rather than relying on it. They also assume a pinned insert names a slot below NUM_TR, which the bench respects by using only slots 0 and 1. Lookup addresses in the bench keep physical results within PA_W bits by using page numbers whose upper bits are zero.

// File: rtl/rtlb_pkg.sv
// Package: shared constants and page-size helpers for the region-tagged TLB.
// Assumes a 64-bit virtual address, 3 region-select bits and a 4 KB minimum page.
package rtlb_pkg;
    localparam int VA_W    = 64;
    localparam int REG_SEL = 3;
    localparam int MIN_SH  = 12;
    localparam int VPN_W   = VA_W - REG_SEL - MIN_SH;   // bits 60:12

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    // Byte-offset width for a page size code.
    function automatic logic [5:0] ps_shift(input logic [3:0] code);
        case (code)
            4'd0:    return 6'd12;
            4'd1:    return 6'd13;
            4'd2:    return 6'd14;
            4'd3:    return 6'd16;
            4'd4:    return 6'd18;
            4'd5:    return 6'd20;
            4'd6:    return 6'd22;
            4'd7:    return 6'd24;
            4'd8:    return 6'd26;
            default: return 6'd28;
        endcase
    endfunction

    // Page-number compare mask: clears the bits below the page for a shift.
    function automatic logic [VPN_W-1:0] vpn_mask(input logic [5:0] sh);
        logic [5:0] n;
        n = sh - 6'(MIN_SH);
        return ~((VPN_W'(1) << n) - VPN_W'(1));
    endfunction
endpackage

// File: rtl/rtlb_region_file.sv
// Region register file: eight region identifiers with one write port and
// two read ports (lookup and insert). Writes are visible from the next cycle.
module rtlb_region_file #(
    parameter int RID_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_idx,
    input  logic [RID_W-1:0] wr_rid,
    input  logic [2:0]       lk_sel,
    output logic [RID_W-1:0] lk_rid,
    input  logic [2:0]       in_sel,
    output logic [RID_W-1:0] in_rid
);
    localparam int NREG = 8;

    logic [RID_W-1:0] rid_q [NREG];

    // Hold region identifiers; cleared to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) rid_q[i] <= '0;
        end else if (wr_en) begin
            rid_q[wr_idx] <= wr_rid;
        end
    end

    // Read the identifiers for the lookup and insert addresses.
    always_comb begin
        lk_rid = rid_q[lk_sel];
        in_rid = rid_q[in_sel];
    end

    assert_rr_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rid_q[$past(wr_idx)] == $past(wr_rid))
        else $error("region register write lost");
endmodule

// File: rtl/rtlb_key_file.sv
// Protection-key register file: NUM_KEYS registers of {valid, key, rwx}.
// Search returns the permissions of the lowest-index valid register whose key
// equals the search key. Assumes keys may repeat; lowest index wins.
module rtlb_key_file #(
    parameter int KEY_W    = 8,
    parameter int NUM_KEYS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_KEYS)-1:0] wr_idx,
    input  logic                        wr_valid,
    input  logic [KEY_W-1:0]            wr_key,
    input  logic [2:0]                  wr_rwx,
    input  logic [KEY_W-1:0]            srch_key,
    output logic                        found,
    output logic [2:0]                  found_rwx
);
    logic [NUM_KEYS-1:0] kv_q;
    logic [KEY_W-1:0]    key_q [NUM_KEYS];
    logic [2:0]          rwx_q [NUM_KEYS];
    logic [NUM_KEYS-1:0] km;

    // Store key registers; all invalid after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kv_q <= '0;
            for (int i = 0; i < NUM_KEYS; i++) begin
                key_q[i] <= '0;
                rwx_q[i] <= '0;
            end
        end else if (wr_en) begin
            kv_q[wr_idx]  <= wr_valid;
            key_q[wr_idx] <= wr_key;
            rwx_q[wr_idx] <= wr_rwx;
        end
    end

    // Per-register key compare.
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
        assign km[g] = kv_q[g] && (key_q[g] == srch_key);
    end

    // Pick the lowest matching register.
    always_comb begin
        found     = 1'b0;
        found_rwx = 3'b000;
        for (int i = NUM_KEYS - 1; i >= 0; i--) begin
            if (km[i]) begin
                found     = 1'b1;
                found_rwx = rwx_q[i];
            end
        end
    end

    assert_found_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (km != '0))
        else $error("key found without a matching register");
endmodule

// File: rtl/rtlb_entry_array.sv
// Entry array: NUM_TR pinned slots followed by NUM_TC cache slots. Provides the
// associative lookup match, inserts (pinned by index, cache by round-robin
// pointer) and the ranged purge of cache slots. Assumes software keeps at most
// one matching entry per lookup.
module rtlb_entry_array
    import rtlb_pkg::*;
#(
    parameter int RID_W  = 18,
    parameter int PPN_W  = 28,
    parameter int KEY_W  = 8,
    parameter int NUM_TR = 2,
    parameter int NUM_TC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    // lookup
    input  logic                      lk_en,
    input  logic [RID_W-1:0]          lk_rid,
    input  logic [VPN_W-1:0]          lk_vpn,
    output logic                      lk_hit,
    output logic [PPN_W-1:0]          lk_ppn,
    output logic [3:0]                lk_ps,
    output logic [2:0]                lk_rwx,
    output logic [1:0]                lk_pl,
    output logic [KEY_W-1:0]          lk_key,
    // insert
    input  logic                      ins_valid,
    input  logic                      ins_pinned,
    input  logic [$clog2(NUM_TR)-1:0] ins_slot,
    input  logic [RID_W-1:0]          ins_rid,
    input  logic [VPN_W-1:0]          ins_vpn,
    input  logic [3:0]                ins_ps,
    input  logic [PPN_W-1:0]          ins_ppn,
    input  logic [2:0]                ins_rwx,
    input  logic [1:0]                ins_pl,
    input  logic [KEY_W-1:0]          ins_key,
    // purge
    input  logic                      pg_valid,
    input  logic [RID_W-1:0]          pg_rid,
    input  logic [VPN_W-1:0]          pg_vpn,
    input  logic [5:0]                pg_log2
);
    localparam int N     = NUM_TR + NUM_TC;
    localparam int IDX_W = $clog2(N);
    localparam int TC_W  = $clog2(NUM_TC);
    localparam int TR_W  = $clog2(NUM_TR);

    logic [N-1:0]     e_vld;
    logic [RID_W-1:0] e_rid [N];
    logic [VPN_W-1:0] e_vpn [N];
    logic [3:0]       e_ps  [N];
    logic [PPN_W-1:0] e_ppn [N];
    logic [2:0]       e_rwx [N];
    logic [1:0]       e_pl  [N];
    logic [KEY_W-1:0] e_key [N];
    logic [TC_W-1:0]  rr_ptr;
    logic [IDX_W-1:0] tgt;
    logic [5:0]       pg_sh;
    logic [N-1:0]     hit_v;
    logic [N-1:0]     pg_hit;

    // Insert target slot and clamped purge window.
    always_comb begin
        tgt = ins_pinned ? IDX_W'(ins_slot) : IDX_W'(NUM_TR) + IDX_W'(rr_ptr);
        if (pg_log2 < 6'd12)      pg_sh = 6'd12;
        else if (pg_log2 > 6'd32) pg_sh = 6'd32;
        else                      pg_sh = pg_log2;
    end

    // Per-slot lookup and purge overlap compare.
    for (genvar g = 0; g < N; g++) begin : g_slot
        logic [5:0] esh;
        logic [5:0] osh;
        assign esh = ps_shift(e_ps[g]);
        assign osh = (esh > pg_sh) ? esh : pg_sh;
        assign hit_v[g] = e_vld[g] && (e_rid[g] == lk_rid) &&
                          (((e_vpn[g] ^ lk_vpn) & vpn_mask(esh)) == '0);
        assign pg_hit[g] = (g >= NUM_TR) && e_vld[g] && (e_rid[g] == pg_rid) &&
                           (((e_vpn[g] ^ pg_vpn) & vpn_mask(osh)) == '0);
    end

    // Update slots: insert wins over purge on the same slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_vld  <= '0;
            rr_ptr <= '0;
            for (int i = 0; i < N; i++) begin
                e_rid[i] <= '0;
                e_vpn[i] <= '0;
                e_ps[i]  <= '0;
                e_ppn[i] <= '0;
                e_rwx[i] <= '0;
                e_pl[i]  <= '0;
                e_key[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (ins_valid && tgt == IDX_W'(i)) begin
                    e_vld[i] <= 1'b1;
                    e_rid[i] <= ins_rid;
                    e_vpn[i] <= ins_vpn;
                    e_ps[i]  <= ins_ps;
                    e_ppn[i] <= ins_ppn;
                    e_rwx[i] <= ins_rwx;
                    e_pl[i]  <= ins_pl;
                    e_key[i] <= ins_key;
                end else if (pg_valid && pg_hit[i]) begin
                    e_vld[i] <= 1'b0;
                end
            end
            if (ins_valid && !ins_pinned)
                rr_ptr <= (rr_ptr == TC_W'(NUM_TC - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // Select the hitting slot (lowest index) and its fields.
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        lk_ps  = '0;
        lk_rwx = '0;
        lk_pl  = '0;
        lk_key = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                lk_hit = 1'b1;
                lk_ppn = e_ppn[i];
                lk_ps  = e_ps[i];
                lk_rwx = e_rwx[i];
                lk_pl  = e_pl[i];
                lk_key = e_key[i];
            end
        end
    end

    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |-> $onehot0(hit_v))
        else $error("more than one entry matched");

    for (genvar t = 0; t < NUM_TR; t++) begin : g_pin_chk
        assert_pinned_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (e_vld[t] && !(ins_valid && ins_pinned && ins_slot == TR_W'(t))) |=> e_vld[t])
            else $error("pinned entry lost");
    end
endmodule

// File: rtl/region_tlb.sv
// Region-tagged TLB top: region lookup, entry match, key search and fault
// classification, with the result registered one clock after the request.
// Assumes at most one entry matches a lookup and PA_W >= 29.
module region_tlb
    import rtlb_pkg::*;
#(
    parameter int PA_W     = 40,
    parameter int RID_W    = 18,
    parameter int KEY_W    = 8,
    parameter int NUM_KEYS = 4,
    parameter int NUM_TR   = 2,
    parameter int NUM_TC   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [63:0]                 req_va,
    input  logic [1:0]                  req_acc,
    input  logic [1:0]                  req_pl,
    output logic                        res_valid,
    output logic                        res_ok,
    output logic                        res_miss,
    output logic                        res_key_fault,
    output logic                        res_acc_fault,
    output logic [PA_W-1:0]             res_pa,
    input  logic                        rr_we,
    input  logic [2:0]                  rr_idx,
    input  logic [RID_W-1:0]            rr_rid,
    input  logic                        pk_we,
    input  logic [$clog2(NUM_KEYS)-1:0] pk_idx,
    input  logic                        pk_valid,
    input  logic [KEY_W-1:0]            pk_key,
    input  logic [2:0]                  pk_rwx,
    input  logic                        ins_valid,
    input  logic                        ins_pinned,
    input  logic [$clog2(NUM_TR)-1:0]   ins_slot,
    input  logic [2:0]                  ins_region,
    input  logic [48:0]                 ins_vpn,
    input  logic [3:0]                  ins_ps,
    input  logic [PA_W-13:0]            ins_ppn,
    input  logic [2:0]                  ins_rwx,
    input  logic [1:0]                  ins_pl,
    input  logic [KEY_W-1:0]            ins_key,
    input  logic                        pg_valid,
    input  logic [RID_W-1:0]            pg_rid,
    input  logic [48:0]                 pg_page,
    input  logic [5:0]                  pg_log2
);
    localparam int PPN_W = PA_W - MIN_SH;

    logic [RID_W-1:0] lk_rid, in_rid;
    logic             hit;
    logic [PPN_W-1:0] h_ppn;
    logic [3:0]       h_ps;
    logic [2:0]       h_rwx;
    logic [1:0]       h_pl;
    logic [KEY_W-1:0] h_key;
    logic             k_found;
    logic [2:0]       k_rwx;
    logic             perm_ok;
    logic [PA_W-1:0]  off_mask;
    logic [PA_W-1:0]  pa_c;

    rtlb_region_file #(.RID_W(RID_W)) u_rr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rr_we), .wr_idx(rr_idx), .wr_rid(rr_rid),
        .lk_sel(req_va[63:61]), .lk_rid(lk_rid),
        .in_sel(ins_region), .in_rid(in_rid)
    );

    rtlb_entry_array #(
        .RID_W(RID_W), .PPN_W(PPN_W), .KEY_W(KEY_W),
        .NUM_TR(NUM_TR), .NUM_TC(NUM_TC)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .lk_en(req_valid), .lk_rid(lk_rid), .lk_vpn(req_va[60:12]),
        .lk_hit(hit), .lk_ppn(h_ppn), .lk_ps(h_ps), .lk_rwx(h_rwx),
        .lk_pl(h_pl), .lk_key(h_key),
        .ins_valid(ins_valid), .ins_pinned(ins_pinned), .ins_slot(ins_slot),
        .ins_rid(in_rid), .ins_vpn(ins_vpn), .ins_ps(ins_ps), .ins_ppn(ins_ppn),
        .ins_rwx(ins_rwx), .ins_pl(ins_pl), .ins_key(ins_key),
        .pg_valid(pg_valid), .pg_rid(pg_rid), .pg_vpn(pg_page), .pg_log2(pg_log2)
    );

    rtlb_key_file #(.KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS)) u_pk (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pk_we), .wr_idx(pk_idx), .wr_valid(pk_valid),
        .wr_key(pk_key), .wr_rwx(pk_rwx),
        .srch_key(h_key), .found(k_found), .found_rwx(k_rwx)
    );

    // Rights check and physical address assembly.
    always_comb begin
        logic [2:0] both;
        both = h_rwx & k_rwx;
        case (acc_e'(req_acc))
            ACC_READ:  perm_ok = both[2];
            ACC_WRITE: perm_ok = both[1];
            ACC_EXEC:  perm_ok = both[0];
            default:   perm_ok = 1'b0;
        endcase
        if (req_pl > h_pl) perm_ok = 1'b0;
        off_mask = (PA_W'(1) << ps_shift(h_ps)) - PA_W'(1);
        pa_c     = ({h_ppn, 12'h000} & ~off_mask) | (req_va[PA_W-1:0] & off_mask);
    end

    // Register the classified lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_ok        <= 1'b0;
            res_miss      <= 1'b0;
            res_key_fault <= 1'b0;
            res_acc_fault <= 1'b0;
            res_pa        <= '0;
        end else begin
            res_valid     <= req_valid;
            res_ok        <= req_valid && hit && k_found && perm_ok;
            res_miss      <= req_valid && !hit;
            res_key_fault <= req_valid && hit && !k_found;
            res_acc_fault <= req_valid && hit && k_found && !perm_ok;
            res_pa        <= (req_valid && hit && k_found && perm_ok) ? pa_c : '0;
        end
    end

    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid)
        else $error("result not one cycle after request");

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid)
        else $error("result without request");

    assert_single_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $countones({res_ok, res_miss, res_key_fault, res_acc_fault}) == 1)
        else $error("outcome flags not exclusive");

    assert_page_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ok) |-> res_pa[11:0] == $past(req_va[11:0]))
        else $error("page offset not carried");
endmodule

// File: tb/test_region_tlb.sv
// Scoreboard bench: driver tasks queue the expected outcome of each lookup,
// a monitor pops and compares one clock later.
module test_region_tlb;
    localparam int PA_W = 40;

    typedef struct {
        int          kind;   // 0 ok, 1 miss, 2 key fault, 3 access fault
        logic [39:0] pa;
        string       tag;
    } exp_t;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic [63:0] req_va = 0;
    logic [1:0]  req_acc = 0, req_pl = 0;
    logic        res_valid, res_ok, res_miss, res_key_fault, res_acc_fault;
    logic [39:0] res_pa;
    logic        rr_we = 0;
    logic [2:0]  rr_idx = 0;
    logic [17:0] rr_rid = 0;
    logic        pk_we = 0, pk_valid = 0;
    logic [1:0]  pk_idx = 0;
    logic [7:0]  pk_key = 0;
    logic [2:0]  pk_rwx = 0;
    logic        ins_valid = 0, ins_pinned = 0;
    logic        ins_slot = 0;
    logic [2:0]  ins_region = 0;
    logic [48:0] ins_vpn = 0;
    logic [3:0]  ins_ps = 0;
    logic [27:0] ins_ppn = 0;
    logic [2:0]  ins_rwx = 0;
    logic [1:0]  ins_pl = 0;
    logic [7:0]  ins_key = 0;
    logic        pg_valid = 0;
    logic [17:0] pg_rid = 0;
    logic [48:0] pg_page = 0;
    logic [5:0]  pg_log2 = 0;

    int   n_vec = 0;
    int   n_bad = 0;
    exp_t q[$];

    always #4 clk = ~clk;   // 125 MHz

    region_tlb i_region_tlb (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_va(req_va), .req_acc(req_acc), .req_pl(req_pl),
        .res_valid(res_valid), .res_ok(res_ok), .res_miss(res_miss),
        .res_key_fault(res_key_fault), .res_acc_fault(res_acc_fault), .res_pa(res_pa),
        .rr_we(rr_we), .rr_idx(rr_idx), .rr_rid(rr_rid),
        .pk_we(pk_we), .pk_idx(pk_idx), .pk_valid(pk_valid), .pk_key(pk_key), .pk_rwx(pk_rwx),
        .ins_valid(ins_valid), .ins_pinned(ins_pinned), .ins_slot(ins_slot),
        .ins_region(ins_region), .ins_vpn(ins_vpn), .ins_ps(ins_ps), .ins_ppn(ins_ppn),
        .ins_rwx(ins_rwx), .ins_pl(ins_pl), .ins_key(ins_key),
        .pg_valid(pg_valid), .pg_rid(pg_rid), .pg_page(pg_page), .pg_log2(pg_log2)
    );

    task automatic lookup(input logic [63:0] va, input int acc, input int pl,
                          input int kind, input logic [39:0] pa, input string tag);
        exp_t e;
        req_valid = 1; req_va = va; req_acc = 2'(acc); req_pl = 2'(pl);
        e.kind = kind; e.pa = (kind == 0) ? pa : 40'h0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic set_rr(input int idx, input logic [17:0] rid);
        rr_we = 1; rr_idx = 3'(idx); rr_rid = rid;
    endtask

    task automatic set_pk(input int idx, input logic v, input logic [7:0] key, input logic [2:0] rwx);
        pk_we = 1; pk_idx = 2'(idx); pk_valid = v; pk_key = key; pk_rwx = rwx;
    endtask

    task automatic set_ins(input logic pin, input logic slot, input logic [63:0] va,
                           input logic [3:0] ps, input logic [27:0] ppn,
                           input logic [2:0] rwx, input logic [1:0] pl, input logic [7:0] key);
        ins_valid = 1; ins_pinned = pin; ins_slot = slot;
        ins_region = va[63:61]; ins_vpn = va[60:12];
        ins_ps = ps; ins_ppn = ppn; ins_rwx = rwx; ins_pl = pl; ins_key = key;
    endtask

    task automatic set_pg(input logic [17:0] rid, input logic [63:0] va, input logic [5:0] lg);
        pg_valid = 1; pg_rid = rid; pg_page = va[60:12]; pg_log2 = lg;
    endtask

    task automatic tick();
        @(negedge clk);
        req_valid = 0; rr_we = 0; pk_we = 0; ins_valid = 0; pg_valid = 0;
    endtask

    // Monitor: compare each result against the head of the queue.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (res_valid) begin
                n_vec++;
                if (q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R9 unexpected result: actual res_valid=1 expected 0");
                end else begin
                    exp_t e;
                    int act;
                    e = q.pop_front();
                    act = res_ok ? 0 : res_miss ? 1 : res_key_fault ? 2 : res_acc_fault ? 3 : 9;
                    if (act != e.kind || res_pa != e.pa) begin
                        n_bad++;
                        $display("FAIL %s: actual kind=%0d pa=%h expected kind=%0d pa=%h",
                                 e.tag, act, res_pa, e.kind, e.pa);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    localparam logic [63:0] VA_T0 = 64'h2000_0000_0040_0000;  // region 1, 1M page
    localparam logic [63:0] VA_T1 = 64'h2000_0000_1000_0000;  // region 1, 4K
    localparam logic [63:0] VA_A  = 64'h2000_0000_3000_0000;
    localparam logic [63:0] VA_B  = 64'h2000_0000_3000_1000;
    localparam logic [63:0] VA_C  = 64'h2000_0000_3000_2000;
    localparam logic [63:0] VA_D  = 64'h0000_0000_3000_2000;  // region 0
    localparam logic [63:0] VA_E  = 64'h2000_0001_0000_0000;  // above 4 GB

    initial begin
        repeat (3) @(negedge clk);
        n_vec++;
        if (res_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 reset: actual res_valid=%b expected 0", res_valid);
        end
        rst_n = 1;
        tick();
        // R10: empty after reset
        lookup(64'h0, 0, 0, 1, 0, "R10 empty array miss"); tick();

        set_rr(1, 18'h00123); tick();
        set_rr(0, 18'h00055); tick();
        set_pk(0, 1, 8'd5, 3'b111); tick();
        set_pk(1, 1, 8'd7, 3'b100); tick();

        // R6 pinned slot 0: 1M page (code 5), slot 1: 4K page
        set_ins(1, 0, VA_T0, 4'd5, 28'h00ABC00, 3'b111, 2'd3, 8'd5); tick();
        set_ins(1, 1, VA_T1, 4'd0, 28'h0000777, 3'b110, 2'd0, 8'd7); tick();

        lookup(VA_T0 | 64'hA_BCDE, 0, 3, 0, 40'hAB_CABC_DE, "R3 1M page pa"); tick();
        lookup(64'h2000_0000_0050_0000, 0, 3, 1, 0, "R2 next 1M page miss"); tick();
        lookup(64'h0000_0000_004A_BCDE, 0, 3, 1, 0, "R1 region 0 rid differs miss"); tick();
        lookup(VA_T1 | 64'h123, 0, 0, 0, 40'h77_7123, "R3 4K page pa"); tick();
        lookup(VA_T1 | 64'h123, 1, 0, 3, 0, "R5 key denies write"); tick();
        lookup(VA_T1 | 64'h123, 0, 1, 3, 0, "R5 privilege above ceiling"); tick();
        lookup(VA_T1 | 64'h123, 2, 0, 3, 0, "R5 entry denies exec"); tick();

        // R4 key fault, then key registered
        set_ins(0, 0, VA_A, 4'd0, 28'h0000100, 3'b111, 2'd3, 8'd9); tick();
        lookup(VA_A | 64'h10, 0, 3, 2, 0, "R4 key absent"); tick();
        set_pk(2, 1, 8'd9, 3'b111); tick();
        lookup(VA_A | 64'h10, 0, 3, 0, 40'h10_0010, "R4 key now present"); tick();

        // R1 region rewrite
        set_rr(1, 18'h00124); tick();
        lookup(VA_T0, 0, 3, 1, 0, "R1 old rid stops matching"); tick();
        set_rr(1, 18'h00123); tick();
        lookup(VA_T0, 0, 3, 0, 40'hAB_C000_00, "R1 rid restored"); tick();

        // R9 same-cycle insert not visible
        set_ins(0, 0, VA_B, 4'd0, 28'h0000101, 3'b111, 2'd3, 8'd5);
        lookup(VA_B, 0, 3, 1, 0, "R9 same-cycle insert unseen"); tick();
        lookup(VA_B | 64'h4, 0, 3, 0, 40'h10_1004, "R9 insert seen next cycle"); tick();

        // R7 round-robin: C, D fill, E replaces A
        set_ins(0, 0, VA_C, 4'd0, 28'h0000102, 3'b111, 2'd3, 8'd5); tick();
        set_ins(0, 0, VA_D, 4'd0, 28'h0000103, 3'b111, 2'd3, 8'd5); tick();
        set_ins(0, 0, VA_E, 4'd0, 28'h0000104, 3'b111, 2'd3, 8'd5); tick();
        lookup(VA_A, 0, 3, 1, 0, "R7 oldest cache entry replaced"); tick();
        lookup(VA_C, 0, 3, 0, 40'h10_2000, "R7 C kept"); tick();
        lookup(VA_D, 0, 3, 0, 40'h10_3000, "R7 D kept"); tick();
        lookup(VA_E, 0, 3, 0, 40'h10_4000, "R7 E present"); tick();
        lookup(VA_T1, 0, 0, 0, 40'h77_7000, "R6 pinned survives cache fills"); tick();

        // R8 purge 4 GB window of rid 0x123
        set_pg(18'h00123, 64'h2000_0000_0000_0000, 6'd32); tick();
        lookup(VA_B, 0, 3, 1, 0, "R8 B purged"); tick();
        lookup(VA_C, 0, 3, 1, 0, "R8 C purged"); tick();
        lookup(VA_D, 0, 3, 0, 40'h10_3000, "R8 other rid kept"); tick();
        lookup(VA_E, 0, 3, 0, 40'h10_4000, "R8 outside window kept"); tick();
        lookup(VA_T0, 0, 3, 0, 40'hAB_C000_00, "R6 pinned not purged"); tick();
        // R8 4K purge with wrong rid, then right rid
        set_pg(18'h00123, VA_D, 6'd12); tick();
        lookup(VA_D, 0, 3, 0, 40'h10_3000, "R8 wrong rid keeps D"); tick();
        set_pg(18'h00055, VA_D, 6'd5); tick();
        lookup(VA_D, 0, 3, 1, 0, "R8 small clamped purge clears D"); tick();

        repeat (3) @(negedge clk);
        n_vec++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 missing results: actual pending=%0d expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule